// File: doc/BRIEF.md
# Dual-mode line prefetcher

This block watches the stream of demand load addresses and produces prefetch requests for whole cache lines. It works in one of two modes chosen by a small control register. In stream mode a table of recent line addresses tracks candidate streams. When consecutive accesses climb or fall one line at a time, the table gains confidence in that stream and requests the line a fixed number of lines ahead, in the direction of travel. In injection mode every demand access triggers a prefetch at the demand address plus a signed byte distance that software has programmed, rounded down to a line boundary. This serves strided loops whose step the compiler knows.

The request leaves through a single registered slot with valid/ready signalling. A candidate that finds the slot still occupied by a stalled request is dropped, never queued, so the block never holds up demand traffic. A control write that changes the mode or clears the enable empties the tracking table.

Top module: `line_prefetcher`

## Requirements
- R1: After reset pf_valid_o is low, the mode is stream (cfg mode bit 0), prefetching is disabled and the distance is zero.
- R2: A cycle with cfg_we_i high loads mode (0 stream, 1 injection), enable and the 32-bit signed distance; a demand in that same cycle is handled with the values held before the write.
- R3: While the enable is low no demand access produces a prefetch.
- R4: In stream mode the line number is address bits [47:8]. A missing line allocates an entry with confidence 0, ascending. An access to last+1 or last-1 of an entry moves it to that line; in the same direction the confidence rises (saturating at 3). When the updated confidence is at least 2, the line last+2 (ascending) or last-2 (descending) is requested, so the third access of a run is the first to prefetch.
- R5: An access one line against an entry's stored direction flips the direction and sets the confidence to 1, so it issues no prefetch.
- R6: An entry never requests the same line twice in a row: a repeated access to its current line issues nothing.
- R7: The table has 8 entries. A miss fills an empty entry first, otherwise it replaces the least recently accessed entry; an access to an entry's current line also counts as use.
- R8: In injection mode with enable set, every demand requests (address + sign-extended distance) with bits [7:0] cleared; the table is left untouched.
- R9: While pf_valid_o is high and pf_ready_i low, pf_valid_o and pf_addr_o hold, and any new candidate is discarded.
- R10: A control write whose mode differs from the current mode, or whose enable is 0, invalidates every table entry; a demand in that cycle produces no prefetch and trains nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dmd_valid_i | input | 1 | Demand access present |
| dmd_addr_i | input | 48 | Demand byte address |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_mode_i | input | 1 | Mode to write: 0 stream, 1 injection |
| cfg_en_i | input | 1 | Enable to write |
| cfg_dist_i | input | 32 | Signed byte distance to write |
| pf_valid_o | output | 1 | Prefetch request valid |
| pf_addr_o | output | 48 | Line-aligned prefetch byte address |
| pf_ready_i | input | 1 | Downstream accepts the request |

## Verification
A control write and a demand access can land in the same cycle, and the outcome depends on which kind of write it is. The bench issues a write that keeps the mode but changes the distance alongside a demand, and expects the old distance in the resulting request. It then issues a mode-changing write alongside a demand in the middle of a confirmed stream, and expects no request at all. The stream's continuation must then rebuild its confidence from zero. A stalled output slot meeting a fresh candidate is the second collision: the held request must survive unchanged and the candidate must vanish.

// File: rtl/lpf_pkg.sv
`timescale 1ns/1ps
package lpf_pkg;
  typedef enum logic {
    PF_STREAM = 1'b0,
    PF_INJECT = 1'b1
  } pf_mode_e;

  typedef logic [1:0] conf_t;
  localparam conf_t CONF_MAX  = 2'd3;
  localparam conf_t CONF_FIRE = 2'd2;
endpackage

// File: rtl/lpf_lru.sv
`timescale 1ns/1ps
module lpf_lru #(
  parameter int unsigned N = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 touch_i,
  input  logic [$clog2(N)-1:0] touch_idx_i,
  output logic [$clog2(N)-1:0] victim_o
);
  localparam int unsigned IDX_W = $clog2(N);

  // ages form a permutation of 0..N-1; N-1 is the oldest
  logic [IDX_W-1:0] age_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) age_q[i] <= IDX_W'(i);
    end else if (touch_i) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == touch_idx_i) age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx_i]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim_o = '0;
    for (int i = 0; i < N; i++)
      if (age_q[i] == IDX_W'(N - 1)) victim_o = IDX_W'(i);
  end
endmodule

// File: rtl/lpf_stream_tbl.sv
`timescale 1ns/1ps
module lpf_stream_tbl
  import lpf_pkg::*;
#(
  parameter int unsigned LINE_W = 40,
  parameter int unsigned N      = 8,
  parameter int unsigned DEGREE = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              dmd_valid_i,
  input  logic [LINE_W-1:0] dmd_line_i,
  output logic              cand_valid_o,
  output logic [LINE_W-1:0] cand_line_o,
  output logic [N-1:0]      vld_o
);
  localparam int unsigned IDX_W = $clog2(N);
  localparam logic [LINE_W-1:0] ONE  = LINE_W'(1);
  localparam logic [LINE_W-1:0] STEP = LINE_W'(DEGREE);

  logic [N-1:0]      vld_q, desc_q, pfv_q;
  logic [LINE_W-1:0] last_q [N];
  logic [LINE_W-1:0] pfl_q  [N];
  conf_t             conf_q [N];

  logic [N-1:0] hit_eq, hit_up, hit_dn;

  for (genvar g = 0; g < N; g++) begin : g_match
    assign hit_eq[g] = vld_q[g] && (dmd_line_i == last_q[g]);
    assign hit_up[g] = vld_q[g] && (dmd_line_i == last_q[g] + ONE);
    assign hit_dn[g] = vld_q[g] && (dmd_line_i == last_q[g] - ONE);
  end

  logic             any_hit, free_found;
  logic [IDX_W-1:0] sel_idx, free_idx, lru_idx, wr_idx;

  always_comb begin
    any_hit    = 1'b0;
    sel_idx    = '0;
    free_found = 1'b0;
    free_idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (!any_hit && (hit_eq[i] || hit_up[i] || hit_dn[i])) begin
        any_hit = 1'b1;
        sel_idx = IDX_W'(i);
      end
      if (!free_found && !vld_q[i]) begin
        free_found = 1'b1;
        free_idx   = IDX_W'(i);
      end
    end
  end

  assign wr_idx = any_hit ? sel_idx : (free_found ? free_idx : lru_idx);

  // next state of the selected entry
  logic              new_desc;
  conf_t             new_conf;
  logic [LINE_W-1:0] target;

  always_comb begin
    if (hit_eq[sel_idx]) begin
      new_desc = desc_q[sel_idx];
      new_conf = conf_q[sel_idx];
    end else begin
      new_desc = hit_dn[sel_idx];
      if (new_desc == desc_q[sel_idx])
        new_conf = (conf_q[sel_idx] == CONF_MAX) ? CONF_MAX : conf_q[sel_idx] + 1'b1;
      else
        new_conf = conf_t'(1);
    end
    target = new_desc ? dmd_line_i - STEP : dmd_line_i + STEP;
  end

  assign cand_valid_o = dmd_valid_i && !clear_i && any_hit && (new_conf >= CONF_FIRE) &&
                        !(pfv_q[sel_idx] && (pfl_q[sel_idx] == target));
  assign cand_line_o  = target;
  assign vld_o        = vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      desc_q <= '0;
      pfv_q  <= '0;
      for (int i = 0; i < N; i++) begin
        last_q[i] <= '0;
        pfl_q[i]  <= '0;
        conf_q[i] <= '0;
      end
    end else if (clear_i) begin
      vld_q <= '0;
    end else if (dmd_valid_i) begin
      vld_q[wr_idx]  <= 1'b1;
      last_q[wr_idx] <= dmd_line_i;
      if (any_hit) begin
        desc_q[wr_idx] <= new_desc;
        conf_q[wr_idx] <= new_conf;
        if (cand_valid_o) begin
          pfv_q[wr_idx] <= 1'b1;
          pfl_q[wr_idx] <= target;
        end
      end else begin
        desc_q[wr_idx] <= 1'b0;
        conf_q[wr_idx] <= '0;
        pfv_q[wr_idx]  <= 1'b0;
      end
    end
  end

  lpf_lru #(.N(N)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (dmd_valid_i && !clear_i),
    .touch_idx_i (wr_idx),
    .victim_o    (lru_idx)
  );
endmodule

// File: rtl/lpf_inject.sv
`timescale 1ns/1ps
module lpf_inject #(
  parameter int unsigned ADDR_W     = 48,
  parameter int unsigned LINE_OFF_W = 8,
  parameter int unsigned DIST_W     = 32
) (
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [DIST_W-1:0]            dist_i,
  output logic [ADDR_W-LINE_OFF_W-1:0] line_o
);
  localparam int unsigned EXT_W = ADDR_W - DIST_W;

  logic [ADDR_W-1:0] sum;
  assign sum    = addr_i + {{EXT_W{dist_i[DIST_W-1]}}, dist_i};
  assign line_o = sum[ADDR_W-1:LINE_OFF_W];
endmodule

// File: rtl/lpf_out_slot.sv
`timescale 1ns/1ps
module lpf_out_slot #(
  parameter int unsigned W = 48
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cand_valid_i,
  input  logic [W-1:0] cand_addr_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] addr_o
);
  logic slot_free;
  assign slot_free = !valid_o || ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
    end else if (cand_valid_i && slot_free) begin
      valid_o <= 1'b1;
      addr_o  <= cand_addr_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/line_prefetcher.sv
`timescale 1ns/1ps
module line_prefetcher
  import lpf_pkg::*;
#(
  parameter int unsigned ADDR_W     = 48,
  parameter int unsigned LINE_OFF_W = 8,
  parameter int unsigned DIST_W     = 32,
  parameter int unsigned ENTRIES    = 8,
  parameter int unsigned DEGREE     = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dmd_valid_i,
  input  logic [ADDR_W-1:0] dmd_addr_i,
  input  logic              cfg_we_i,
  input  logic              cfg_mode_i,
  input  logic              cfg_en_i,
  input  logic [DIST_W-1:0] cfg_dist_i,
  output logic              pf_valid_o,
  output logic [ADDR_W-1:0] pf_addr_o,
  input  logic              pf_ready_i
);
  localparam int unsigned LINE_W = ADDR_W - LINE_OFF_W;

  pf_mode_e          mode_q;
  logic              en_q;
  logic [DIST_W-1:0] dist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= PF_STREAM;
      en_q   <= 1'b0;
      dist_q <= '0;
    end else if (cfg_we_i) begin
      mode_q <= pf_mode_e'(cfg_mode_i);
      en_q   <= cfg_en_i;
      dist_q <= cfg_dist_i;
    end
  end

  logic tbl_clr, dmd_ok;
  assign tbl_clr = cfg_we_i && ((cfg_mode_i != logic'(mode_q)) || !cfg_en_i);
  assign dmd_ok  = dmd_valid_i && en_q && !tbl_clr;

  logic              st_cand;
  logic [LINE_W-1:0] st_line, inj_line, cand_line;
  logic [ENTRIES-1:0] tbl_vld;

  lpf_stream_tbl #(
    .LINE_W (LINE_W),
    .N      (ENTRIES),
    .DEGREE (DEGREE)
  ) u_stream (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (tbl_clr),
    .dmd_valid_i  (dmd_ok && (mode_q == PF_STREAM)),
    .dmd_line_i   (dmd_addr_i[ADDR_W-1:LINE_OFF_W]),
    .cand_valid_o (st_cand),
    .cand_line_o  (st_line),
    .vld_o        (tbl_vld)
  );

  lpf_inject #(
    .ADDR_W     (ADDR_W),
    .LINE_OFF_W (LINE_OFF_W),
    .DIST_W     (DIST_W)
  ) u_inject (
    .addr_i (dmd_addr_i),
    .dist_i (dist_q),
    .line_o (inj_line)
  );

  logic cand_valid;
  assign cand_valid = (mode_q == PF_INJECT) ? dmd_ok : st_cand;
  assign cand_line  = (mode_q == PF_INJECT) ? inj_line : st_line;

  lpf_out_slot #(.W(ADDR_W)) u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cand_valid_i (cand_valid),
    .cand_addr_i  ({cand_line, {LINE_OFF_W{1'b0}}}),
    .ready_i      (pf_ready_i),
    .valid_o      (pf_valid_o),
    .addr_o       (pf_addr_o)
  );
endmodule

// File: rtl/lpf_chk.sv
`timescale 1ns/1ps
module lpf_chk #(
  parameter int unsigned ADDR_W     = 48,
  parameter int unsigned LINE_OFF_W = 8,
  parameter int unsigned ENTRIES    = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               dmd_valid_i,
  input logic               cfg_we_i,
  input logic               cfg_mode_i,
  input logic               cfg_en_i,
  input logic               mode_q,
  input logic               en_q,
  input logic [ENTRIES-1:0] tbl_vld,
  input logic               pf_valid_o,
  input logic [ADDR_W-1:0]  pf_addr_o,
  input logic               pf_ready_i
);
  // R9
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_valid_o && !pf_ready_i) |=> (pf_valid_o && $stable(pf_addr_o)));

  // R8
  line_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pf_valid_o |-> (pf_addr_o[LINE_OFF_W-1:0] == '0));

  // R10
  table_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && ((cfg_mode_i != mode_q) || !cfg_en_i)) |=> (tbl_vld == '0));

  // R3
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !(pf_valid_o && !pf_ready_i)) |=> !pf_valid_o);

  // R8
  inject_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmd_valid_i && en_q && mode_q && !cfg_we_i && (!pf_valid_o || pf_ready_i)) |=> pf_valid_o);
endmodule

bind line_prefetcher lpf_chk #(
  .ADDR_W     (ADDR_W),
  .LINE_OFF_W (LINE_OFF_W),
  .ENTRIES    (ENTRIES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .dmd_valid_i (dmd_valid_i),
  .cfg_we_i    (cfg_we_i),
  .cfg_mode_i  (cfg_mode_i),
  .cfg_en_i    (cfg_en_i),
  .mode_q      (mode_q),
  .en_q        (en_q),
  .tbl_vld     (tbl_vld),
  .pf_valid_o  (pf_valid_o),
  .pf_addr_o   (pf_addr_o),
  .pf_ready_i  (pf_ready_i)
);

// File: tb/sim_line_prefetcher.sv
`timescale 1ns/1ps
module sim_line_prefetcher;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dmd_valid = 1'b0;
  logic [47:0] dmd_addr = '0;
  logic        cfg_we = 1'b0;
  logic        cfg_mode = 1'b0;
  logic        cfg_en = 1'b0;
  logic [31:0] cfg_dist = '0;
  logic        pf_ready = 1'b1;
  logic        pf_valid;
  logic [47:0] pf_addr;

  always #2.5 clk = ~clk;

  line_prefetcher u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .dmd_valid_i (dmd_valid),
    .dmd_addr_i  (dmd_addr),
    .cfg_we_i    (cfg_we),
    .cfg_mode_i  (cfg_mode),
    .cfg_en_i    (cfg_en),
    .cfg_dist_i  (cfg_dist),
    .pf_valid_o  (pf_valid),
    .pf_addr_o   (pf_addr),
    .pf_ready_i  (pf_ready)
  );

  int checks = 0;
  int errors = 0;
  logic [47:0] exp_q[$];
  string       tag_q[$];
  string       cur_req = "R1";

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] la(input logic [39:0] line, input logic [7:0] off);
    return {line, off};
  endfunction

  // monitor: every accepted request is compared against the scoreboard
  always @(negedge clk) begin
    if (rst_n && pf_valid && pf_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, {cur_req, " unexpected prefetch"}, pf_addr, 48'h0);
      end else begin
        logic [47:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(pf_addr == e, t, pf_addr, e);
      end
    end
  end

  task automatic demand(input logic [47:0] a, input bit exp_v, input logic [47:0] e, input string req);
    @(negedge clk);
    cur_req   = req;
    dmd_valid = 1'b1;
    dmd_addr  = a;
    if (exp_v) begin
      exp_q.push_back(e);
      tag_q.push_back(req);
    end
    @(negedge clk);
    dmd_valid = 1'b0;
  endtask

  task automatic cfg(input bit m, input bit en, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mode = m; cfg_en = en; cfg_dist = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_dmd(input bit m, input bit en, input logic [31:0] d,
                         input logic [47:0] a, input bit exp_v, input logic [47:0] e, input string req);
    @(negedge clk);
    cur_req = req;
    cfg_we = 1'b1; cfg_mode = m; cfg_en = en; cfg_dist = d;
    dmd_valid = 1'b1; dmd_addr = a;
    if (exp_v) begin
      exp_q.push_back(e);
      tag_q.push_back(req);
    end
    @(negedge clk);
    cfg_we = 1'b0;
    dmd_valid = 1'b0;
  endtask

  task automatic set_ready(input bit r);
    @(posedge clk);
    #1 pf_ready = r;
  endtask

  task automatic drain(input string req);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, {req, " missing prefetch"}, 48'(exp_q.size()), 48'h0);
    exp_q.delete();
    tag_q.delete();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    chk(pf_valid == 1'b0, "R1 reset valid", {47'h0, pf_valid}, 48'h0);

    // R3: disabled by default, a run of lines yields nothing
    for (int k = 0; k < 4; k++) demand(la(40'h300 + 40'(k), 8'h10), 1'b0, '0, "R3");
    drain("R3");

    // R4: ascending stream
    cfg(1'b0, 1'b1, 32'h0);
    demand(la(40'h100, 8'h40), 1'b0, '0, "R4");
    demand(la(40'h101, 8'h00), 1'b0, '0, "R4");
    demand(la(40'h102, 8'hff), 1'b1, la(40'h104, 8'h00), "R4");
    demand(la(40'h103, 8'h08), 1'b1, la(40'h105, 8'h00), "R4");
    // R6: same line again, no repeat of line 105
    demand(la(40'h103, 8'h80), 1'b0, '0, "R6");
    // R5: reversal resets confidence, then descends
    demand(la(40'h102, 8'h00), 1'b0, '0, "R5");
    demand(la(40'h101, 8'h00), 1'b1, la(40'h0ff, 8'h00), "R5");
    // R4: descending stream
    demand(la(40'h5000, 8'h20), 1'b0, '0, "R4");
    demand(la(40'h4fff, 8'h20), 1'b0, '0, "R4");
    demand(la(40'h4ffe, 8'h20), 1'b1, la(40'h4ffc, 8'h00), "R4");
    demand(la(40'h4ffd, 8'h20), 1'b1, la(40'h4ffb, 8'h00), "R4");
    drain("R4");

    // R7: untouched stream is evicted after eight newer lines
    cfg(1'b0, 1'b0, 32'h0);
    cfg(1'b0, 1'b1, 32'h0);
    demand(la(40'h20000, 8'h0), 1'b0, '0, "R7");
    demand(la(40'h20001, 8'h0), 1'b0, '0, "R7");
    for (int k = 1; k <= 8; k++) demand(la(40'h30000 + 40'(k * 16), 8'h0), 1'b0, '0, "R7");
    demand(la(40'h20002, 8'h0), 1'b0, '0, "R7 evicted");
    drain("R7");

    // R7: a touched stream survives, the oldest other entry goes
    cfg(1'b0, 1'b0, 32'h0);
    cfg(1'b0, 1'b1, 32'h0);
    demand(la(40'h20000, 8'h0), 1'b0, '0, "R7");
    demand(la(40'h20001, 8'h0), 1'b0, '0, "R7");
    for (int k = 1; k <= 7; k++) demand(la(40'h30000 + 40'(k * 16), 8'h0), 1'b0, '0, "R7");
    demand(la(40'h20001, 8'h44), 1'b0, '0, "R7");
    demand(la(40'h30000 + 40'(8 * 16), 8'h0), 1'b0, '0, "R7");
    demand(la(40'h20002, 8'h0), 1'b1, la(40'h20004, 8'h0), "R7 kept");
    drain("R7");

    // R10: disable write empties the table
    demand(la(40'h7000, 8'h0), 1'b0, '0, "R10");
    demand(la(40'h7001, 8'h0), 1'b0, '0, "R10");
    demand(la(40'h7002, 8'h0), 1'b1, la(40'h7004, 8'h0), "R10");
    cfg(1'b0, 1'b0, 32'h0);
    cfg(1'b0, 1'b1, 32'h0);
    demand(la(40'h7003, 8'h0), 1'b0, '0, "R10 after disable");
    drain("R10");

    // R9: stall holds the request and drops the next candidate
    demand(la(40'h900, 8'h0), 1'b0, '0, "R9");
    demand(la(40'h901, 8'h0), 1'b0, '0, "R9");
    set_ready(1'b0);
    demand(la(40'h902, 8'h0), 1'b1, la(40'h904, 8'h0), "R9");
    demand(la(40'h903, 8'h0), 1'b0, '0, "R9");
    chk(pf_valid == 1'b1, "R9 held valid", {47'h0, pf_valid}, 48'h1);
    chk(pf_addr == la(40'h904, 8'h0), "R9 held addr", pf_addr, la(40'h904, 8'h0));
    set_ready(1'b1);
    demand(la(40'h904, 8'h0), 1'b1, la(40'h906, 8'h0), "R9");
    drain("R9");

    // R10: mode-changing write with a demand in the same cycle
    demand(la(40'h8000, 8'h0), 1'b0, '0, "R10");
    demand(la(40'h8001, 8'h0), 1'b0, '0, "R10");
    demand(la(40'h8002, 8'h0), 1'b1, la(40'h8004, 8'h0), "R10");
    cfg_dmd(1'b1, 1'b1, 32'h100, la(40'h8003, 8'h0), 1'b0, '0, "R10 same cycle");
    drain("R10");

    // R8: injection targets
    demand(48'h0000_0000_5000, 1'b1, 48'h0000_0000_5100, "R8");
    cfg(1'b1, 1'b1, 32'h400);
    demand(48'h0000_0000_1234, 1'b1, 48'h0000_0000_1600, "R8");
    demand(48'h0000_abcd_ef12, 1'b1, 48'h0000_abcd_f300, "R8");
    cfg(1'b1, 1'b1, 32'hffff_fd00);
    demand(48'h0000_0001_0080, 1'b1, 48'h0000_0000_fd00, "R8 negative");
    demand(48'h8000_0000_1000, 1'b1, 48'h8000_0000_0d00, "R8 negative");
    drain("R8");

    // R2: non-clearing write alongside a demand uses the old distance
    cfg_dmd(1'b1, 1'b1, 32'h1000, 48'h0000_0000_2000, 1'b1, 48'h0000_0000_1d00, "R2 old distance");
    demand(48'h0000_0000_2000, 1'b1, 48'h0000_0000_3000, "R2 new distance");
    drain("R2");

    // R10: back to stream mode, earlier stream state is gone
    cfg(1'b0, 1'b1, 32'h0);
    demand(la(40'h8003, 8'h0), 1'b0, '0, "R10");
    demand(la(40'h8004, 8'h0), 1'b0, '0, "R10");
    demand(la(40'h8005, 8'h0), 1'b1, la(40'h8007, 8'h0), "R10");
    drain("R10");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule